// File: doc/BRIEF.md
# Latched BCD Seven-Segment Decoder

This block turns a four-bit binary-coded decimal digit into seven active-high drive levels for the segments of a common-cathode display. A level-sensitive holding latch sits in front of the decoder. While the active-low hold control is LOW the latch is transparent and the display follows the input. When the hold control rises, the digit present at that moment is frozen, and the display keeps showing that digit for as long as the control stays HIGH.

Two active-low overrides act on the display stage only. A lamp check lights every segment, and it wins over everything else. A blanking control turns every segment off. Neither override alters the frozen digit, so normal display of that digit returns as soon as both overrides are released. Input codes ten to fifteen are not decimal digits and give a dark display. The segment vector is captured in an output register with a synchronous active-high reset. The output therefore shows the effect of the inputs one clock after they are applied.

Top module: `seg7_latch_decoder`

## Requirements
- R1: While `hold_n` is LOW, `seg_out` at the clock edge after the inputs are applied equals the glyph of the current `bcd_in`, with `lamp_chk_n` and `blank_n` HIGH.
- R2: The rising edge of `hold_n` freezes the value of `bcd_in` present at that moment. While `hold_n` stays HIGH, changes on `bcd_in` leave `seg_out` unchanged.
- R3: While `lamp_chk_n` is LOW, `seg_out` becomes 7'h7F one clock later, whatever the state of every other input.
- R4: While `lamp_chk_n` is HIGH and `blank_n` is LOW, `seg_out` becomes 7'h00 one clock later.
- R5: The overrides never modify the frozen digit. After both return HIGH with `hold_n` still HIGH, the glyph of the frozen digit is shown again.
- R6: Codes 10 to 15 give `seg_out` = 7'h00.
- R7: The glyph bit order is bit 6 = segment a, bit 5 = b, bit 4 = c, bit 3 = d, bit 2 = e, bit 1 = f, bit 0 = g. The glyphs for digits 0 to 9 are 7E, 30, 6D, 79, 33, 5B, 1F (6 without segment a), 70, 7F and 73 (9 without segment d).
- R8: A synchronous reset drives `seg_out` to 7'h00 and clears the frozen digit to 0. After reset, with `hold_n` HIGH, the glyph of digit 0 is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| bcd_in | input | 4 | BCD digit |
| hold_n | input | 1 | Active-low latch control: LOW means transparent, HIGH means hold |
| lamp_chk_n | input | 1 | Active-low lamp check, lights all segments |
| blank_n | input | 1 | Active-low blanking, turns all segments off |
| seg_out | output | 7 | Segment drive, bit 6 = a down to bit 0 = g, active HIGH |

## Verification
With the latch transparent, all sixteen codes are swept under all four combinations of the two overrides. This separates the glyph table, the dark codes above nine and the override priority, including lamp check over blanking. For every code, the digit is then frozen and `bcd_in` is walked through all sixteen values. This shows that held input changes are ignored and that capture happens on the rising edge of `hold_n`. Finally, each override is pulsed while the digit is held. This shows that the frozen value survives both overrides.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

  localparam int SEG_W     = 7;
  localparam int NUM_GLYPH = 10;

  // Per-segment membership masks: bit k set means digit k lights it.
  // Row index matches the output bit (6 = a ... 0 = g).
  localparam logic [SEG_W-1:0][NUM_GLYPH-1:0] SEG_LIT_MASK = {
    10'b1110101101,  // a
    10'b1110011111,  // b
    10'b1111111011,  // c
    10'b0101101101,  // d
    10'b0101000101,  // e
    10'b1101110001,  // f
    10'b1101111100   // g
  };

  typedef enum logic [1:0] {
    DRV_GLYPH = 2'd0,
    DRV_DARK  = 2'd1,
    DRV_LIT   = 2'd2
  } drv_mode_e;

endpackage

// File: rtl/seg7_hold_latch.sv
module seg7_hold_latch #(
  parameter int DIGIT_W = 4
) (
  input  logic               rst,
  input  logic               hold_n,
  input  logic [DIGIT_W-1:0] d_in,
  output logic [DIGIT_W-1:0] d_held
);

  always_latch begin
    if (rst)
      d_held = '0;
    else if (!hold_n)
      d_held = d_in;
  end

endmodule

// File: rtl/seg7_glyph_decode.sv
module seg7_glyph_decode
  import seg7_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] code,
  output logic [SEG_W-1:0]   glyph
);

  localparam int CODES = 2 ** DIGIT_W;

  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    logic [CODES-1:0] lit_tbl;
    assign lit_tbl  = CODES'(SEG_LIT_MASK[s]);
    assign glyph[s] = lit_tbl[code];
  end

endmodule

// File: rtl/seg7_drive_stage.sv
module seg7_drive_stage
  import seg7_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lamp_chk_n,
  input  logic             blank_n,
  input  logic [SEG_W-1:0] glyph,
  output logic [SEG_W-1:0] seg_q
);

  drv_mode_e            mode;
  logic [SEG_W-1:0]     seg_d;

  always_comb begin
    if (!lamp_chk_n)   mode = DRV_LIT;
    else if (!blank_n) mode = DRV_DARK;
    else               mode = DRV_GLYPH;
  end

  always_comb begin
    unique case (mode)
      DRV_LIT:  seg_d = '1;
      DRV_DARK: seg_d = '0;
      default:  seg_d = glyph;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) seg_q <= '0;
    else     seg_q <= seg_d;
  end

endmodule

// File: rtl/seg7_latch_decoder.sv
module seg7_latch_decoder #(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] bcd_in,
  input  logic               hold_n,
  input  logic               lamp_chk_n,
  input  logic               blank_n,
  output logic [6:0]         seg_out
);

  logic [DIGIT_W-1:0] held_digit;
  logic [6:0]         glyph;

  seg7_hold_latch #(.DIGIT_W(DIGIT_W)) i_latch (
    .rst    (rst),
    .hold_n (hold_n),
    .d_in   (bcd_in),
    .d_held (held_digit)
  );

  seg7_glyph_decode #(.DIGIT_W(DIGIT_W)) i_dec (
    .code  (held_digit),
    .glyph (glyph)
  );

  seg7_drive_stage i_drv (
    .clk        (clk),
    .rst        (rst),
    .lamp_chk_n (lamp_chk_n),
    .blank_n    (blank_n),
    .glyph      (glyph),
    .seg_q      (seg_out)
  );

endmodule

// File: rtl/seg7_chk.sv
module seg7_chk #(
  parameter int DIGIT_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [DIGIT_W-1:0] bcd_in,
  input logic               hold_n,
  input logic               lamp_chk_n,
  input logic               blank_n,
  input logic [6:0]         seg_out
);

  p_lamp_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(lamp_chk_n)) |-> (seg_out == 7'h7F));

  p_blank_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lamp_chk_n) && !$past(blank_n)) |-> (seg_out == 7'h00));

  p_dark_code_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lamp_chk_n) && $past(blank_n) && !$past(hold_n)
     && ($past(bcd_in) > 4'd9)) |-> (seg_out == 7'h00));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(hold_n) && $past(hold_n, 2)
     && $past(lamp_chk_n) && $past(lamp_chk_n, 2)
     && $past(blank_n) && $past(blank_n, 2)) |-> $stable(seg_out));

  p_reset_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (seg_out == 7'h00));

endmodule

bind seg7_latch_decoder seg7_chk #(.DIGIT_W(DIGIT_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .bcd_in     (bcd_in),
  .hold_n     (hold_n),
  .lamp_chk_n (lamp_chk_n),
  .blank_n    (blank_n),
  .seg_out    (seg_out)
);

// File: tb/test_seg7_latch_decoder.sv
module test_seg7_latch_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bcd_in = 4'd0;
  logic       hold_n = 1'b1;
  logic       lamp_chk_n = 1'b1;
  logic       blank_n = 1'b1;
  logic [6:0] seg_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  seg7_latch_decoder i_seg7_latch_decoder (
    .clk        (clk),
    .rst        (rst),
    .bcd_in     (bcd_in),
    .hold_n     (hold_n),
    .lamp_chk_n (lamp_chk_n),
    .blank_n    (blank_n),
    .seg_out    (seg_out)
  );

  // Glyphs from R7; codes above nine are dark (R6).
  function automatic logic [6:0] ref_glyph(input int c);
    case (c)
      0: return 7'h7E;  1: return 7'h30;  2: return 7'h6D;  3: return 7'h79;
      4: return 7'h33;  5: return 7'h5B;  6: return 7'h1F;  7: return 7'h70;
      8: return 7'h7F;  9: return 7'h73;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    n_chk++;
    if (seg_out !== exp) begin
      n_fail++;
      $display("FAIL %s: seg_out=%h expected=%h (bcd=%0d hold_n=%b lt=%b bl=%b)",
               req, seg_out, exp, bcd_in, hold_n, lamp_chk_n, blank_n);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R8: reset state
    bcd_in = 4'd5;
    repeat (3) @(negedge clk);
    check("R8", 7'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R8", ref_glyph(0));

    // R1, R3, R4, R6, R7: transparent sweep under every override combination
    hold_n = 1'b0;
    for (int ov = 0; ov < 4; ov++) begin
      for (int c = 0; c < 16; c++) begin
        lamp_chk_n = ov[1];
        blank_n    = ov[0];
        bcd_in     = 4'(c);
        @(negedge clk);
        if (!ov[1])      check("R3", 7'h7F);
        else if (!ov[0]) check("R4", 7'h00);
        else if (c > 9)  check("R6", 7'h00);
        else             check("R7", ref_glyph(c));
      end
    end

    // R2, R5: capture, hold against input changes, overrides while held
    lamp_chk_n = 1'b1;
    blank_n    = 1'b1;
    for (int c = 0; c < 16; c++) begin
      hold_n = 1'b0;
      bcd_in = 4'(c);
      @(negedge clk);
      check("R1", ref_glyph(c));
      hold_n = 1'b1;
      @(negedge clk);
      check("R2", ref_glyph(c));
      for (int d = 0; d < 16; d++) begin
        bcd_in = 4'(15 - d);
        @(negedge clk);
        check("R2", ref_glyph(c));
      end
      lamp_chk_n = 1'b0;
      bcd_in     = 4'(c + 3);
      @(negedge clk);
      check("R3", 7'h7F);
      lamp_chk_n = 1'b1;
      blank_n    = 1'b0;
      @(negedge clk);
      check("R4", 7'h00);
      blank_n = 1'b1;
      @(negedge clk);
      check("R5", ref_glyph(c));
    end

    // R8: reset clears the frozen digit while holding
    bcd_in = 4'd8;
    rst    = 1'b1;
    @(negedge clk);
    check("R8", 7'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R8", ref_glyph(0));

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule